// File: doc/BRIEF.md
# NOR Flash Read-Path Multiplexer

This block produces the read data of an emulated NOR flash device. A separate write-side decoder holds the current command mode and the write cycle. This block takes that mode and forms each read from one of four sources: array data, identification words, a status byte, or a byte from the built-in query table. The query table describes the device geometry, which comes from parameters.

The block also owns the status byte. Bit 6 toggles on every status read. Bit 7 tracks program and erase events. An erase countdown signals when a chip or sector erase completes. The block keeps a flag that shows whether the device is mapped directly as array memory. A write at cycle 0 clears this flag. The flag comes back either when an erase finishes outside bypass mode or after a long enough run of idle reads. When the block reads under a mode code it does not recognise, it returns array data and asks the decoder to fall back to read-array mode.

Top module: `flash_read_mux`

## Requirements
- R1: The word index is bits [7:0] of the byte offset, shifted right according to `bus_sel`: 0 means no shift (8-bit bus), 1 means shift by one (16-bit bus), 2 means shift by two (32-bit bus). Code 3 means no shift.
- R2: Mode 0x00 (read array) and mode 0x80 (erase setup pending) return `arr_data`.
- R3: In mode 0x90 (identify), index 0 returns parameter ID0, index 1 returns ID1 and index 2 returns 0. Each is zero-extended to the data width.
- R4: In mode 0x90, index 0x0E returns ID2 and index 0x0F returns ID3. When the low byte of that word is 0xFF, the read returns `arr_data` instead. Every other index in mode 0x90 returns `arr_data`.
- R5: Modes 0xA0, 0x10 and 0x30 return the status byte as it was before the read. After each such read, status bit 6 is inverted. Status bits 5..0 are always 0.
- R6: Mode 0x98 (query) returns table byte `idx` when `idx` < 0x4D, and 0 otherwise. The table holds 0x51/0x52/0x59 at 0x10..0x12 and 0x50/0x52/0x49/0x31/0x30 at 0x40..0x44. At 0x27 it holds log2 of the chip size in bytes.
- R7: A `prog_evt` sets status bit 7 to the inverse of `prog_bit7`. The start of an erase clears bit 7. Erase expiry inverts bit 7.
- R8: An erase pulse captured at clock edge E0 raises `done_evt` for exactly one cycle after edge E0+N. N is CHIP_CYC for `erase_chip` and SECT_CYC for `erase_sector`. Along with it, `done_cycle` reads 2 when `bypass_i` is high and 0 otherwise.
- R9: An erase expiry with `bypass_i` low sets `direct_map`. An expiry with `bypass_i` high leaves it unchanged.
- R10: `wr_idle` clears `direct_map` and the read count. While `direct_map` is low, each read with `cycle_i` == 0 is counted. The read numbered LAZY_LIM+1 sets `direct_map`. Reads with a nonzero cycle are not counted.
- R11: A read under any other mode code returns `arr_data` and pulses `mode_reset` for one cycle.
- R12: After reset, `rd_data`, `rd_valid`, `status_o`, `done_evt` and `mode_reset` are 0, and `direct_map` is 1.
- R13: `rd_data` and `rd_valid` are registered. They update one cycle after `rd_en`, and `rd_valid` is low in the cycle after a cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| rd_off | input | 8 | Low byte of the read byte offset |
| bus_sel | input | 2 | Bus width code: 0 for 8-bit, 1 for 16-bit, 2 for 32-bit |
| mode_i | input | 8 | Currently latched command mode |
| cycle_i | input | 3 | Current write cycle count |
| bypass_i | input | 1 | Bypass mode active |
| arr_data | input | DW | Array read data for this offset |
| wr_idle | input | 1 | A write was accepted at cycle 0 |
| prog_evt | input | 1 | Program data written |
| prog_bit7 | input | 1 | Bit 7 of the programmed data |
| erase_chip | input | 1 | Chip erase starts |
| erase_sector | input | 1 | Sector erase starts |
| rd_data | output | DW | Registered read data |
| rd_valid | output | 1 | Read data valid |
| status_o | output | 8 | Status byte |
| direct_map | output | 1 | Device mapped directly as array memory |
| done_evt | output | 1 | One-cycle erase completion pulse |
| done_cycle | output | 3 | Cycle the decoder resumes at on completion |
| mode_reset | output | 1 | Request to force read-array mode |

## Verification
The hardest situation to reach is the lazy return to direct mapping. It needs a long run of reads at cycle 0 with no write in between. The stimulus first clears the flag with `wr_idle` and issues a partial run. It then clears the flag again so the count restarts, and inserts a read at a nonzero cycle that must not count. Only then does it issue exactly LAZY_LIM reads, checks that the flag is still low, and adds one more read. The erase window is reached with shortened cycle parameters. The bench checks the cycle before completion as well as the completion cycle itself, in both bypass states.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
  localparam logic [7:0] M_READ   = 8'h00;
  localparam logic [7:0] M_ESETUP = 8'h80;
  localparam logic [7:0] M_IDENT  = 8'h90;
  localparam logic [7:0] M_PROG   = 8'hA0;
  localparam logic [7:0] M_CHIPER = 8'h10;
  localparam logic [7:0] M_SECTER = 8'h30;
  localparam logic [7:0] M_QUERY  = 8'h98;

  localparam int QTBL_DEPTH = 8'h4D;

  typedef enum logic [2:0] {
    MC_ARRAY,
    MC_IDENT,
    MC_STATUS,
    MC_QUERY,
    MC_UNKNOWN
  } mode_class_e;

  function automatic mode_class_e classify(input logic [7:0] m);
    case (m)
      M_READ, M_ESETUP:           classify = MC_ARRAY;
      M_IDENT:                    classify = MC_IDENT;
      M_PROG, M_CHIPER, M_SECTER: classify = MC_STATUS;
      M_QUERY:                    classify = MC_QUERY;
      default:                    classify = MC_UNKNOWN;
    endcase
  endfunction
endpackage

// File: rtl/flash_rd_index.sv
module flash_rd_index (
  input  logic [7:0] off,
  input  logic [1:0] bus_sel,
  output logic [7:0] idx
);
  always_comb begin
    case (bus_sel)
      2'd1:    idx = {1'b0, off[7:1]};
      2'd2:    idx = {2'b00, off[7:2]};
      default: idx = off;
    endcase
  end
endmodule

// File: rtl/flash_rd_qtable.sv
module flash_rd_qtable #(
  parameter int SECT_BYTES = 65536,
  parameter int NUM_SECT   = 64
) (
  input  logic [7:0] idx,
  output logic [7:0] byte_o
);
  import flash_rd_pkg::*;
  localparam int          CHIP_LOG2 = $clog2(SECT_BYTES * NUM_SECT);
  localparam logic [31:0] NBM1      = 32'(NUM_SECT - 1);
  localparam logic [31:0] SLEN      = 32'(SECT_BYTES);

  logic [7:0] raw;

  always_comb begin
    case (idx)
      8'h10: raw = 8'h51;
      8'h11: raw = 8'h52;
      8'h12: raw = 8'h59;
      8'h13: raw = 8'h02;
      8'h15: raw = 8'h40;
      8'h1B: raw = 8'h27;
      8'h1C: raw = 8'h36;
      8'h1F: raw = 8'h07;
      8'h21: raw = 8'h09;
      8'h22: raw = 8'h0C;
      8'h23: raw = 8'h01;
      8'h25: raw = 8'h0A;
      8'h26: raw = 8'h0D;
      8'h27: raw = 8'(CHIP_LOG2);
      8'h28: raw = 8'h02;
      8'h2C: raw = 8'h01;
      8'h2D: raw = NBM1[7:0];
      8'h2E: raw = NBM1[15:8];
      8'h2F: raw = SLEN[15:8];
      8'h30: raw = SLEN[23:16];
      8'h40: raw = 8'h50;
      8'h41: raw = 8'h52;
      8'h42: raw = 8'h49;
      8'h43: raw = 8'h31;
      8'h44: raw = 8'h30;
      default: raw = 8'h00;
    endcase
    byte_o = (idx < 8'(QTBL_DEPTH)) ? raw : 8'h00;
  end
endmodule

// File: rtl/flash_rd_status.sv
module flash_rd_status #(
  parameter int CHIP_CYC = 250_000_000,
  parameter int SECT_CYC = 25_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stat_rd,
  input  logic       prog_evt,
  input  logic       prog_bit7,
  input  logic       erase_chip,
  input  logic       erase_sector,
  input  logic       bypass_i,
  output logic [7:0] status_o,
  output logic       tmr_fire,
  output logic       done_evt,
  output logic [2:0] done_cycle
);
  localparam int MAXC = (CHIP_CYC > SECT_CYC) ? CHIP_CYC : SECT_CYC;
  localparam int TW   = $clog2(MAXC + 1);

  logic          b7, b6, busy;
  logic [TW-1:0] cnt;
  logic          start;

  assign start    = erase_chip | erase_sector;
  assign tmr_fire = busy && (cnt == TW'(1)) && !start;
  assign status_o = {b7, b6, 6'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      b7         <= 1'b0;
      b6         <= 1'b0;
      busy       <= 1'b0;
      cnt        <= '0;
      done_evt   <= 1'b0;
      done_cycle <= 3'd0;
    end else begin
      done_evt <= 1'b0;
      if (stat_rd) b6 <= ~b6;
      if (start) begin
        b7   <= 1'b0;
        busy <= 1'b1;
        cnt  <= erase_chip ? TW'(CHIP_CYC) : TW'(SECT_CYC);
      end else begin
        if (prog_evt) b7 <= ~prog_bit7;
        if (busy) begin
          if (cnt == TW'(1)) begin
            busy       <= 1'b0;
            cnt        <= '0;
            done_evt   <= 1'b1;
            done_cycle <= bypass_i ? 3'd2 : 3'd0;
            if (!prog_evt) b7 <= ~b7;
          end else begin
            cnt <= cnt - TW'(1);
          end
        end
      end
    end
  end

  assert_bit6_flip_R5: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> status_o[6] != $past(status_o[6]));
  assert_bit6_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !stat_rd |=> $stable(status_o[6]));
  assert_erase_clr_R7: assert property (@(posedge clk) disable iff (rst)
    start |=> !status_o[7]);
  assert_prog_bit7_R7: assert property (@(posedge clk) disable iff (rst)
    (prog_evt && !start) |=> status_o[7] == !$past(prog_bit7));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done_evt |=> !done_evt);
endmodule

// File: rtl/flash_rd_lazy.sv
module flash_rd_lazy #(
  parameter int LAZY_LIM = 42
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_cnt_en,
  input  logic wr_idle,
  input  logic restore,
  output logic direct_map
);
  localparam int LW = $clog2(LAZY_LIM + 2);
  logic [LW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      direct_map <= 1'b1;
      cnt        <= '0;
    end else if (wr_idle) begin
      direct_map <= 1'b0;
      cnt        <= '0;
    end else if (restore) begin
      direct_map <= 1'b1;
    end else if (!direct_map && rd_cnt_en) begin
      if (cnt == LW'(LAZY_LIM)) direct_map <= 1'b1;
      cnt <= cnt + LW'(1);
    end
  end

  assert_wr_leave_R10: assert property (@(posedge clk) disable iff (rst)
    wr_idle |=> !direct_map);
  assert_restore_R9: assert property (@(posedge clk) disable iff (rst)
    (restore && !wr_idle) |=> direct_map);
endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux #(
  parameter int          DW         = 32,
  parameter logic [15:0] ID0        = 16'h0001,
  parameter logic [15:0] ID1        = 16'h227E,
  parameter logic [15:0] ID2        = 16'h2210,
  parameter logic [15:0] ID3        = 16'hFFFF,
  parameter int          SECT_BYTES = 65536,
  parameter int          NUM_SECT   = 64,
  parameter int          CHIP_CYC   = 250_000_000,
  parameter int          SECT_CYC   = 25_000_000,
  parameter int          LAZY_LIM   = 42
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [7:0]    rd_off,
  input  logic [1:0]    bus_sel,
  input  logic [7:0]    mode_i,
  input  logic [2:0]    cycle_i,
  input  logic          bypass_i,
  input  logic [DW-1:0] arr_data,
  input  logic          wr_idle,
  input  logic          prog_evt,
  input  logic          prog_bit7,
  input  logic          erase_chip,
  input  logic          erase_sector,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [7:0]    status_o,
  output logic          direct_map,
  output logic          done_evt,
  output logic [2:0]    done_cycle,
  output logic          mode_reset
);
  import flash_rd_pkg::*;

  logic [7:0]    idx;
  logic [7:0]    tbl_byte;
  logic          tmr_fire;
  logic          stat_rd;
  mode_class_e   cls;
  logic [DW-1:0] nxt;

  flash_rd_index u_index (.off(rd_off), .bus_sel(bus_sel), .idx(idx));

  flash_rd_qtable #(.SECT_BYTES(SECT_BYTES), .NUM_SECT(NUM_SECT)) u_qtable (
    .idx(idx), .byte_o(tbl_byte));

  assign cls     = classify(mode_i);
  assign stat_rd = rd_en && (cls == MC_STATUS);

  flash_rd_status #(.CHIP_CYC(CHIP_CYC), .SECT_CYC(SECT_CYC)) u_status (
    .clk(clk), .rst(rst), .stat_rd(stat_rd), .prog_evt(prog_evt),
    .prog_bit7(prog_bit7), .erase_chip(erase_chip),
    .erase_sector(erase_sector), .bypass_i(bypass_i), .status_o(status_o),
    .tmr_fire(tmr_fire), .done_evt(done_evt), .done_cycle(done_cycle));

  flash_rd_lazy #(.LAZY_LIM(LAZY_LIM)) u_lazy (
    .clk(clk), .rst(rst), .rd_cnt_en(rd_en && (cycle_i == 3'd0)),
    .wr_idle(wr_idle), .restore(tmr_fire && !bypass_i),
    .direct_map(direct_map));

  always_comb begin
    nxt = '0;
    case (cls)
      MC_IDENT: begin
        case (idx)
          8'h00: nxt[15:0] = ID0;
          8'h01: nxt[15:0] = ID1;
          8'h02: nxt = '0;
          8'h0E: if (ID2[7:0] == 8'hFF) nxt = arr_data; else nxt[15:0] = ID2;
          8'h0F: if (ID3[7:0] == 8'hFF) nxt = arr_data; else nxt[15:0] = ID3;
          default: nxt = arr_data;
        endcase
      end
      MC_STATUS: nxt[7:0] = status_o;
      MC_QUERY:  nxt[7:0] = tbl_byte;
      default:   nxt = arr_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data    <= '0;
      rd_valid   <= 1'b0;
      mode_reset <= 1'b0;
    end else begin
      rd_valid   <= rd_en;
      mode_reset <= rd_en && (cls == MC_UNKNOWN);
      if (rd_en) rd_data <= nxt;
    end
  end

  assert_latency_R13: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  assert_idle_R13: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  assert_unknown_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cls == MC_UNKNOWN) |=> (mode_reset && rd_data == $past(arr_data)));
endmodule

// File: tb/flash_read_mux_bench.sv
module flash_read_mux_bench;
  localparam int DW     = 32;
  localparam int CHIP_N = 40;
  localparam int SECT_N = 12;
  localparam int LAZY   = 42;

  logic          clk = 1'b0;
  logic          rst;
  logic          rd_en, bypass_i, wr_idle, prog_evt, prog_bit7;
  logic          erase_chip, erase_sector;
  logic [7:0]    rd_off, mode_i;
  logic [1:0]    bus_sel;
  logic [2:0]    cycle_i;
  logic [DW-1:0] arr_data;
  logic [DW-1:0] rd_data;
  logic          rd_valid, direct_map, done_evt, mode_reset;
  logic [7:0]    status_o;
  logic [2:0]    done_cycle;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  eb6 = 0, eb7 = 0;

  always #10 clk = ~clk;

  flash_read_mux #(.DW(DW), .CHIP_CYC(CHIP_N), .SECT_CYC(SECT_N),
                   .LAZY_LIM(LAZY)) u_flash_read_mux (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_off(rd_off), .bus_sel(bus_sel),
    .mode_i(mode_i), .cycle_i(cycle_i), .bypass_i(bypass_i),
    .arr_data(arr_data), .wr_idle(wr_idle), .prog_evt(prog_evt),
    .prog_bit7(prog_bit7), .erase_chip(erase_chip),
    .erase_sector(erase_sector), .rd_data(rd_data), .rd_valid(rd_valid),
    .status_o(status_o), .direct_map(direct_map), .done_evt(done_evt),
    .done_cycle(done_cycle), .mode_reset(mode_reset));

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [7:0] m, input logic [2:0] cyc,
                         input logic [1:0] bs, input logic [7:0] off);
    @(negedge clk);
    mode_i = m; cycle_i = cyc; bus_sel = bs; rd_off = off; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_wr_idle;
    @(negedge clk); wr_idle = 1'b1;
    @(negedge clk); wr_idle = 1'b0;
  endtask

  function automatic logic [31:0] stat_word();
    return {24'b0, eb7, eb6, 6'b0};
  endfunction

  task automatic t_reset;
    chk("R12 rd_data", rd_data, 0);
    chk("R12 rd_valid", {31'b0, rd_valid}, 0);
    chk("R12 status", {24'b0, status_o}, 0);
    chk("R12 direct_map", {31'b0, direct_map}, 1);
    chk("R12 done_evt", {31'b0, done_evt}, 0);
    chk("R12 mode_reset", {31'b0, mode_reset}, 0);
  endtask

  task automatic t_array;
    arr_data = 32'hCAFE_F00D;
    do_read(8'h00, 3'd0, 2'd0, 8'h13);
    chk("R2 read mode", rd_data, 32'hCAFE_F00D);
    chk("R13 valid after read", {31'b0, rd_valid}, 1);
    @(negedge clk);
    chk("R13 valid low when idle", {31'b0, rd_valid}, 0);
    arr_data = 32'h1234_5678;
    do_read(8'h80, 3'd4, 2'd1, 8'h02);
    chk("R2 erase setup mode", rd_data, 32'h1234_5678);
  endtask

  task automatic t_index;
    do_read(8'h98, 3'd7, 2'd0, 8'h10);
    chk("R1 8-bit idx 0x10", rd_data, 32'h51);
    do_read(8'h98, 3'd7, 2'd1, 8'h20);
    chk("R1 16-bit idx 0x10", rd_data, 32'h51);
    do_read(8'h98, 3'd7, 2'd2, 8'h44);
    chk("R1 32-bit idx 0x11", rd_data, 32'h52);
    do_read(8'h98, 3'd7, 2'd1, 8'h4E);
    chk("R1 16-bit idx 0x27 size", rd_data, 32'h16);
    do_read(8'h98, 3'd7, 2'd3, 8'h12);
    chk("R1 code 3 no shift", rd_data, 32'h59);
  endtask

  task automatic t_query;
    do_read(8'h98, 3'd7, 2'd0, 8'h40);
    chk("R6 table 0x40", rd_data, 32'h50);
    do_read(8'h98, 3'd7, 2'd0, 8'h43);
    chk("R6 table 0x43", rd_data, 32'h31);
    do_read(8'h98, 3'd7, 2'd0, 8'h4D);
    chk("R6 idx 0x4D beyond", rd_data, 32'h0);
    do_read(8'h98, 3'd7, 2'd0, 8'hAA);
    chk("R6 idx 0xAA beyond", rd_data, 32'h0);
  endtask

  task automatic t_ident;
    arr_data = 32'hA5A5_0F0F;
    do_read(8'h90, 3'd3, 2'd1, 8'h00);
    chk("R3 idx0 ID0", rd_data, 32'h0001);
    do_read(8'h90, 3'd3, 2'd1, 8'h02);
    chk("R3 idx1 ID1", rd_data, 32'h227E);
    do_read(8'h90, 3'd3, 2'd1, 8'h04);
    chk("R3 idx2 zero", rd_data, 32'h0);
    do_read(8'h90, 3'd3, 2'd1, 8'h1C);
    chk("R4 idx 0x0E ID2", rd_data, 32'h2210);
    do_read(8'h90, 3'd3, 2'd1, 8'h1E);
    chk("R4 idx 0x0F fallback", rd_data, 32'hA5A5_0F0F);
    do_read(8'h90, 3'd3, 2'd1, 8'h06);
    chk("R4 other idx array", rd_data, 32'hA5A5_0F0F);
  endtask

  task automatic t_status;
    do_read(8'hA0, 3'd3, 2'd0, 8'h00);
    chk("R5 first status read", rd_data, stat_word()); eb6 = ~eb6;
    do_read(8'h10, 3'd6, 2'd0, 8'h00);
    chk("R5 second read toggled", rd_data, stat_word()); eb6 = ~eb6;
    do_read(8'h30, 3'd6, 2'd0, 8'h00);
    chk("R5 third read", rd_data, stat_word()); eb6 = ~eb6;
    @(negedge clk); prog_evt = 1'b1; prog_bit7 = 1'b0;
    @(negedge clk); prog_evt = 1'b0; eb7 = 1'b1;
    chk("R7 program bit7 inverse", {24'b0, status_o}, stat_word());
    @(negedge clk); prog_evt = 1'b1; prog_bit7 = 1'b1;
    @(negedge clk); prog_evt = 1'b0; eb7 = 1'b0;
    chk("R7 program bit7 inverse 1", {24'b0, status_o}, stat_word());
    do_read(8'hA0, 3'd3, 2'd0, 8'h00);
    chk("R5 status via read", rd_data, stat_word()); eb6 = ~eb6;
  endtask

  task automatic t_erase;
    bypass_i = 1'b0;
    pulse_wr_idle();
    chk("R10 wr_idle clears map", {31'b0, direct_map}, 0);
    @(negedge clk); prog_evt = 1'b1; prog_bit7 = 1'b0;
    @(negedge clk); prog_evt = 1'b0; eb7 = 1'b1;
    @(negedge clk); erase_sector = 1'b1;
    @(negedge clk); erase_sector = 1'b0; eb7 = 1'b0;
    chk("R7 erase start clears bit7", {24'b0, status_o}, stat_word());
    repeat (SECT_N - 1) @(negedge clk);
    chk("R8 sector not done early", {31'b0, done_evt}, 0);
    chk("R9 map still low", {31'b0, direct_map}, 0);
    @(negedge clk); eb7 = 1'b1;
    chk("R8 sector done", {31'b0, done_evt}, 1);
    chk("R8 done_cycle no bypass", {29'b0, done_cycle}, 0);
    chk("R7 expiry flips bit7", {24'b0, status_o}, stat_word());
    chk("R9 map restored", {31'b0, direct_map}, 1);
    @(negedge clk);
    chk("R8 done one cycle", {31'b0, done_evt}, 0);

    bypass_i = 1'b1;
    pulse_wr_idle();
    @(negedge clk); erase_chip = 1'b1;
    @(negedge clk); erase_chip = 1'b0; eb7 = 1'b0;
    repeat (CHIP_N - 1) @(negedge clk);
    chk("R8 chip not done early", {31'b0, done_evt}, 0);
    @(negedge clk); eb7 = 1'b1;
    chk("R8 chip done", {31'b0, done_evt}, 1);
    chk("R8 done_cycle bypass", {29'b0, done_cycle}, 2);
    chk("R9 bypass keeps map low", {31'b0, direct_map}, 0);
    chk("R7 chip expiry bit7", {24'b0, status_o}, stat_word());
    bypass_i = 1'b0;
  endtask

  task automatic t_lazy;
    pulse_wr_idle();
    for (int i = 0; i < 20; i++) do_read(8'h00, 3'd0, 2'd0, 8'h00);
    pulse_wr_idle();
    do_read(8'h00, 3'd2, 2'd0, 8'h00);
    for (int i = 0; i < LAZY; i++) do_read(8'h00, 3'd0, 2'd0, 8'h00);
    chk("R10 map low after limit reads", {31'b0, direct_map}, 0);
    do_read(8'h00, 3'd0, 2'd0, 8'h00);
    chk("R10 map restored after limit+1", {31'b0, direct_map}, 1);
  endtask

  task automatic t_unknown;
    arr_data = 32'hDEAD_BEEF;
    do_read(8'h55, 3'd5, 2'd0, 8'h00);
    chk("R11 unknown returns array", rd_data, 32'hDEAD_BEEF);
    chk("R11 mode_reset pulse", {31'b0, mode_reset}, 1);
    @(negedge clk);
    chk("R11 mode_reset one cycle", {31'b0, mode_reset}, 0);
  endtask

  initial begin
    rst = 1'b1; rd_en = 0; bypass_i = 0; wr_idle = 0; prog_evt = 0;
    prog_bit7 = 0; erase_chip = 0; erase_sector = 0; rd_off = 0;
    mode_i = 0; bus_sel = 0; cycle_i = 0; arr_data = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_array();
    t_index();
    t_query();
    t_ident();
    t_status();
    t_erase();
    t_lazy();
    t_unknown();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule